// File: doc/BRIEF.md
# Flag-Setting Add and Move Unit

This combinational core covers the arithmetic and move part of a 32-bit data-processing stage. It takes a first operand from the register file, a second operand that a barrel shifter has already prepared (with the carry that shifter produced), and the current N, Z, C and V flags. It returns a result for four operations: move, move-inverted, add, and add-with-carry.

A set-flags bit decides whether the unit also computes new flags. Move operations take their carry from the shifter. Arithmetic operations derive carry by comparing the sum with the first operand. When flags are requested and the destination is the program counter, the unit leaves the flags alone. It raises a request instead, telling the surrounding pipeline to reload the status register from its saved copy.

Register access, the shifter and condition evaluation are outside this block.

Top module: `addmov_unit`

## Requirements
- R1: With opcode 2'b00 (move), `result` equals `shf_val`.
- R2: With opcode 2'b01 (move-inverted), `result` equals the bitwise inverse of `shf_val`.
- R3: With opcode 2'b10 (add), `result` is `op_a + shf_val` modulo 2^32. The flag C (bit 1 of `flags_out`) is 1 exactly when that sum is unsigned-less-than `op_a`.
- R4: With opcode 2'b11 (add-with-carry) and input C (bit 1 of `flags_in`) at 1, `result` is `op_a + shf_val + 1`, and C is 1 when the result is unsigned-less-than-or-equal to `op_a`. With input C at 0, the R3 rule applies.
- R5: For add and add-with-carry, V (bit 0) is bit 31 of `~(op_a ^ shf_val) & (op_a ^ result)`, which is signed overflow.
- R6: For move and move-inverted with flags set, C takes `shf_cy` and V keeps its input value.
- R7: Whenever flags are updated, N (bit 3) equals `result[31]`, and Z (bit 2) is 1 exactly when all 32 result bits are zero.
- R8: With `set_flags` at 0, `flags_out` equals `flags_in` and `restore_req` is 0. The result is still produced.
- R9: With `set_flags` at 1 and `dst_pc` at 1, `restore_req` is 1 and `flags_out` equals `flags_in`. The result is still produced as in R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| shf_val | input | 32 | Shifter operand |
| shf_cy | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| op_sel | input | 2 | Operation: 00 move, 01 move-inverted, 10 add, 11 add-with-carry |
| set_flags | input | 1 | Request flag update |
| dst_pc | input | 1 | Destination is the program counter |
| result | output | 32 | Operation result |
| flags_out | output | 4 | New flags {N,Z,C,V} |
| restore_req | output | 1 | Reload status register from its saved copy |

## Verification
The add path is tried with several kinds of operands:
- Operands whose sum wraps to exactly zero, which separates the carry comparison from the zero flag.
- Sums that land exactly on `op_a` with carry-in set, which is the only place where less-than and less-than-or-equal give different answers.
- Sign-boundary pairs such as 0x7FFFFFFF+1 and 0x80000000+0x80000000, which expose errors in the overflow term.

The move paths use all-zero and all-one operands with both shifter carry values and both input V values. These patterns show whether carry is taken from the shifter and whether V is held. Random vectors sweep every combination of opcode, set-flags, destination and input flags.

// File: rtl/addmov_pkg.sv
package addmov_pkg;
  typedef enum logic [1:0] {
    OP_MOVE = 2'b00,
    OP_MOVN = 2'b01,
    OP_ADD  = 2'b10,
    OP_ADDC = 2'b11
  } addmov_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/addmov_mover.sv
module addmov_mover #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] src,
  input  logic             invert,
  output logic [WIDTH-1:0] dst
);
  always_comb begin
    dst = invert ? ~src : src;
  end
endmodule

// File: rtl/addmov_adder.sv
module addmov_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  logic [WIDTH-1:0] ovf_vec;

  always_comb begin
    sum = a + b + {{(WIDTH-1){1'b0}}, cin};
    // Wrap detection by comparison: a carried-in sum wraps when it does not exceed a.
    if (cin) cout = (sum <= a);
    else     cout = (sum < a);
    ovf_vec = ~(a ^ b) & (a ^ sum);
    ovf     = ovf_vec[WIDTH-1];
  end
endmodule

// File: rtl/addmov_flags.sv
module addmov_flags
  import addmov_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  input  logic             arith,
  input  logic             shf_cy,
  input  logic             add_c,
  input  logic             add_v,
  input  nzcv_t            cur,
  input  logic             set_flags,
  input  logic             dst_pc,
  output nzcv_t            nxt,
  output logic             restore
);
  nzcv_t computed;

  always_comb begin
    computed.n = res[WIDTH-1];
    computed.z = (res == '0);
    computed.c = arith ? add_c : shf_cy;
    computed.v = arith ? add_v : cur.v;

    restore = set_flags & dst_pc;
    if (set_flags && !dst_pc) nxt = computed;
    else                      nxt = cur;
  end
endmodule

// File: rtl/addmov_unit.sv
module addmov_unit
  import addmov_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] shf_val,
  input  logic             shf_cy,
  input  logic [3:0]       flags_in,
  input  logic [1:0]       op_sel,
  input  logic             set_flags,
  input  logic             dst_pc,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_out,
  output logic             restore_req
);
  addmov_op_e       op;
  nzcv_t            cur_f;
  nzcv_t            nxt_f;
  logic [WIDTH-1:0] mov_res;
  logic [WIDTH-1:0] sum;
  logic             add_c;
  logic             add_v;
  logic             arith;
  logic             cin;

  always_comb begin
    op    = addmov_op_e'(op_sel);
    cur_f = nzcv_t'(flags_in);
    arith = op_sel[1];
    cin   = (op == OP_ADDC) ? cur_f.c : 1'b0;
  end

  addmov_mover #(.WIDTH(WIDTH)) u_mover (
    .src    (shf_val),
    .invert (op == OP_MOVN),
    .dst    (mov_res)
  );

  addmov_adder #(.WIDTH(WIDTH)) u_adder (
    .a    (op_a),
    .b    (shf_val),
    .cin  (cin),
    .sum  (sum),
    .cout (add_c),
    .ovf  (add_v)
  );

  always_comb begin
    result = arith ? sum : mov_res;
  end

  addmov_flags #(.WIDTH(WIDTH)) u_flags (
    .res       (result),
    .arith     (arith),
    .shf_cy    (shf_cy),
    .add_c     (add_c),
    .add_v     (add_v),
    .cur       (cur_f),
    .set_flags (set_flags),
    .dst_pc    (dst_pc),
    .nxt       (nxt_f),
    .restore   (restore_req)
  );

  assign flags_out = nxt_f;
endmodule

// File: rtl/addmov_unit_chk.sv
module addmov_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] shf_val,
  input logic             shf_cy,
  input logic [3:0]       flags_in,
  input logic [1:0]       op_sel,
  input logic             set_flags,
  input logic             dst_pc,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags_out,
  input logic             restore_req
);
  always_comb begin
    if (op_sel == 2'b00)
      a_r1_move_pass: assert (result == shf_val);
    if (op_sel == 2'b01)
      a_r2_move_inv: assert (result == ~shf_val);
    if (set_flags && !dst_pc) begin
      a_r7_neg_flag: assert (flags_out[3] == result[WIDTH-1]);
      a_r7_zero_flag: assert (flags_out[2] == (result == '0));
    end
    if (set_flags && !dst_pc && !op_sel[1])
      a_r6_move_cv: assert (flags_out[1] == shf_cy && flags_out[0] == flags_in[0]);
    if (!set_flags)
      a_r8_flags_hold: assert (flags_out == flags_in && !restore_req);
    if (set_flags && dst_pc)
      a_r9_restore: assert (restore_req && flags_out == flags_in);
  end
endmodule

bind addmov_unit addmov_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a        (op_a),
  .shf_val     (shf_val),
  .shf_cy      (shf_cy),
  .flags_in    (flags_in),
  .op_sel      (op_sel),
  .set_flags   (set_flags),
  .dst_pc      (dst_pc),
  .result      (result),
  .flags_out   (flags_out),
  .restore_req (restore_req)
);

// File: tb/addmov_unit_test.sv
`timescale 1ns/1ps
module addmov_unit_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a, shf_val, result;
  logic        shf_cy, set_flags, dst_pc, restore_req;
  logic [3:0]  flags_in, flags_out;
  logic [1:0]  op_sel;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  addmov_unit uut (
    .op_a(op_a), .shf_val(shf_val), .shf_cy(shf_cy), .flags_in(flags_in),
    .op_sel(op_sel), .set_flags(set_flags), .dst_pc(dst_pc),
    .result(result), .flags_out(flags_out), .restore_req(restore_req)
  );

  // Behavioural reference: wide integer arithmetic, signed comparisons for overflow.
  task automatic expect_of(output logic [31:0] e_res, output logic [3:0] e_fl,
                           output logic e_rst);
    longint unsigned wide;
    logic c, v;
    bit arith;
    arith = (op_sel >= 2);
    c = flags_in[1];
    v = flags_in[0];
    case (op_sel)
      2'd0: begin e_res = shf_val;  c = shf_cy; end
      2'd1: begin e_res = ~shf_val; c = shf_cy; end
      default: begin
        wide = longint'(op_a) + longint'(shf_val) +
               ((op_sel == 2'd3 && flags_in[1]) ? 64'd1 : 64'd0);
        e_res = wide[31:0];
        c = wide[32];
        v = ($signed(op_a) >= 0) == ($signed(shf_val) >= 0) &&
            (($signed(e_res) >= 0) != ($signed(op_a) >= 0));
      end
    endcase
    if (arith == 0) v = flags_in[0];
    e_rst = set_flags && dst_pc;
    if (set_flags && !dst_pc) e_fl = {e_res[31], e_res == 0, c, v};
    else                      e_fl = flags_in;
  endtask

  task automatic check(input string req);
    logic [31:0] e_res;
    logic [3:0]  e_fl;
    logic        e_rst;
    expect_of(e_res, e_fl, e_rst);
    total++;
    if (result !== e_res) begin
      bad++;
      $display("FAIL %s result op=%0d a=%h b=%h: got %h exp %h", req, op_sel, op_a, shf_val, result, e_res);
    end
    total++;
    if (flags_out !== e_fl) begin
      bad++;
      $display("FAIL %s flags op=%0d a=%h b=%h fi=%b: got %b exp %b", req, op_sel, op_a, shf_val, flags_in, flags_out, e_fl);
    end
    total++;
    if (restore_req !== e_rst) begin
      bad++;
      $display("FAIL %s restore: got %b exp %b", req, restore_req, e_rst);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic cy, input logic [3:0] fi, input logic s, input logic pc,
                       input string req);
    @(posedge clk);
    #1;
    op_sel = op; op_a = a; shf_val = b; shf_cy = cy; flags_in = fi;
    set_flags = s; dst_pc = pc;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_sel = 0; op_a = 0; shf_val = 0; shf_cy = 0; flags_in = 0;
    set_flags = 0; dst_pc = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle");

    // R1 / R2 / R6: moves with both shifter carries and both V inputs
    apply(2'd0, 32'h1234_5678, 32'h0000_0000, 1'b1, 4'b0001, 1, 0, "R1 R6 R7 mov zero");
    apply(2'd0, 32'h0, 32'h8000_0000, 1'b0, 4'b0010, 1, 0, "R1 R6 R7 mov neg");
    apply(2'd1, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'b1111, 1, 0, "R2 R6 mvn to zero");
    apply(2'd1, 32'h0, 32'h0000_0000, 1'b1, 4'b0000, 1, 0, "R2 R6 mvn to ones");
    // R3: wrap to zero, no carry, overflow boundaries
    apply(2'd2, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000, 1, 0, "R3 R7 add wrap zero");
    apply(2'd2, 32'h1, 32'h2, 1'b1, 4'b0000, 1, 0, "R3 add small");
    apply(2'd2, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'b0000, 1, 0, "R5 add pos ovf");
    apply(2'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000, 1, 0, "R5 add neg ovf");
    // R4: carry-in set, sum equal to a (b = all ones)
    apply(2'd3, 32'h0000_0005, 32'hFFFF_FFFF, 1'b0, 4'b0010, 1, 0, "R4 adc sum eq a");
    apply(2'd3, 32'h0000_0005, 32'hFFFF_FFFF, 1'b0, 4'b0000, 1, 0, "R4 adc cin0");
    apply(2'd3, 32'h7FFF_FFFF, 32'h0, 1'b0, 4'b0010, 1, 0, "R4 R5 adc ovf");
    apply(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'b0010, 1, 0, "R4 adc max");
    // R8: no flag update
    apply(2'd2, 32'hFFFF_FFFF, 32'h1, 1'b1, 4'b1010, 0, 0, "R8 add noS");
    apply(2'd0, 32'h0, 32'h0, 1'b1, 4'b0101, 0, 1, "R8 mov noS pc");
    // R9: restore request
    apply(2'd2, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b1001, 1, 1, "R9 add pc");
    apply(2'd1, 32'h0, 32'h0, 1'b1, 4'b0110, 1, 1, "R9 mvn pc");

    for (int i = 0; i < 3000; i++) begin
      apply(2'($urandom), (i % 7 == 0) ? 32'hFFFF_FFF0 + 32'($urandom % 16) : $urandom,
            (i % 5 == 0) ? 32'h8000_0000 : $urandom, 1'($urandom), 4'($urandom),
            1'($urandom), ($urandom % 4) == 0, "R3 R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule